// File: doc/BRIEF.md
# Dual-Output Waveform Timer Channel

This block is a single timer channel that drives two pulse-width outputs, `pwm_a` and `pwm_b`, from one shared up-counter, so both outputs always have the same period. The counter advances on a selectable tick. It returns to zero on the tick after it matches the period compare value, held in the period register. Each output has its own compare register: the first-output compare for `pwm_a` and the second-output compare for `pwm_b`. Each output changes level through a small action table that is not a fixed duty comparator. The table holds one 2-bit action for the output's own compare match, one for the period match and one for the software trigger.

A host programs the channel through a plain write strobe and reads it back through a read strobe. The mode word holds the tick select, a waveform enable and the six action fields, and it reads back as written. This lets a host find a channel that is already set up and keep its settings. A command word starts or stops the tick gating and fires the software trigger. The trigger zeroes the counter and applies each output's trigger action at once. Pulse widths of 0% and 100% are made by stopping the counter with a trigger whose action forces the level. The compare actions are left at none, so the level holds until the channel is set up again.

Top module: `wavetmr_chan`

## Requirements
- R1: After a synchronous reset both outputs are 0, the counter reads 0, the channel is stopped and the mode word reads 0.
- R2: While running with the waveform enable set, the counter steps by one on each selected tick. On a tick where it equals the period value it goes to 0, so the period of both outputs is (period value + 1) ticks.
- R3: Output A applies its own-compare action on a tick where the counter equals the first-output compare value, and its period action on a period match. With clear on its own compare and set on the period match, it is high for (compare + 1) of every (period + 1) ticks.
- R4: Output B behaves the same way using the second-output compare value and its own action fields, independently of output A.
- R5: With the polarity reversed (set on the output's own compare, clear on the period match), the output is high for (period − compare) of every (period + 1) ticks.
- R6: A command write with the trigger bit (bit 2) zeroes the counter and applies each output's trigger action at that edge. The start bit (bit 0) makes the channel run. The stop bit (bit 1) stops it and wins over bit 0. When stopped, the counter and both outputs hold, which gives steady 0% and 100% levels.
- R7: Priority per output is trigger, then period match, then own-compare match. A trigger also suppresses all compare events in its cycle. When the own compare equals the period value, the period action wins.
- R8: Action codes are 00 none, 01 set, 10 clear and 11 toggle.
- R9: The tick select (mode bits 2:0) picks one of four tick sources: code 0 is every clock, code 1 is every 8 clocks, code 2 is every 32 clocks and code 3 is every 128 clocks. Code 4 picks the `slow_tick` input, and codes 5 to 7 give no tick.
- R10: Mode word layout: bits 2:0 tick select, bit 3 waveform enable, then output A actions for own compare (5:4), period match (7:6) and trigger (9:8), then output B actions in the same order (11:10, 13:12, 15:14). It reads back as written, with upper bits 0. With bit 3 clear the counter does not advance.
- R11: Compare and period values written while the channel runs take effect from the next tick, without a trigger.
- R12: Register addresses: 0 mode, 1 command (write only), 2 first-output compare, 3 second-output compare, 4 period, 5 counter (read only). Read data appears on the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | Slow tick enable, one clock wide, synchronous to clk |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 3 | Read register address |
| rd_data | output | DATA_W | Read data, valid the cycle after rd_en |
| pwm_a | output | 1 | Waveform output A |
| pwm_b | output | 1 | Waveform output B |

## Verification
Two actions can fall in one cycle: the own-compare action and the period action, when the compare value equals the period value. A software trigger written while the channel runs can also land on a period match, for example with the period value at 0, where every tick is a match. The bench sets the compare equal to the period value and checks that the output stays high for a whole window. It then fires a clearing trigger on a running channel with a period of 0. It checks that the output is low on the cycle after the write and that the period match sets it high again on the next cycle.

// File: rtl/wavetmr_pkg.sv
package wavetmr_pkg;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_SET  = 2'b01,
        ACT_CLR  = 2'b10,
        ACT_TGL  = 2'b11
    } act_e;

    typedef struct packed {
        act_e       b_sw;
        act_e       b_rc;
        act_e       b_cmp;
        act_e       a_sw;
        act_e       a_rc;
        act_e       a_cmp;
        logic       wave_en;
        logic [2:0] clk_sel;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);
    localparam int ADDR_W = 3;
    localparam int N_PIN  = 2;
    localparam int N_DIV  = 4;

    localparam logic [ADDR_W-1:0] ADR_MODE = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_CMD  = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_CPA  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_CPB  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_PER  = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_CNT  = 3'd5;

    localparam int CMD_START = 0;
    localparam int CMD_STOP  = 1;
    localparam int CMD_TRIG  = 2;

    function automatic logic apply_act(input logic cur, input act_e a);
        case (a)
            ACT_SET: return 1'b1;
            ACT_CLR: return 1'b0;
            ACT_TGL: return ~cur;
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/wavetmr_regs.sv
module wavetmr_regs
    import wavetmr_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CW-1:0]     cnt,
    output logic [DW-1:0]     rd_data,
    output mode_t             mode,
    output logic [CW-1:0]     cmp_a,
    output logic [CW-1:0]     cmp_b,
    output logic [CW-1:0]     per,
    output logic              run,
    output logic              sw_fire
);

    logic cmd_wr;

    assign cmd_wr  = wr_en && (wr_addr == ADR_CMD);
    assign sw_fire = cmd_wr && wr_data[CMD_TRIG];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode  <= '0;
            cmp_a <= '0;
            cmp_b <= '0;
            per   <= '0;
            run   <= 1'b0;
        end else begin
            if (wr_en) begin
                case (wr_addr)
                    ADR_MODE: mode  <= mode_t'(wr_data[MODE_W-1:0]);
                    ADR_CPA:  cmp_a <= wr_data[CW-1:0];
                    ADR_CPB:  cmp_b <= wr_data[CW-1:0];
                    ADR_PER:  per   <= wr_data[CW-1:0];
                    default:  ;
                endcase
            end
            if (cmd_wr) begin
                if (wr_data[CMD_STOP])
                    run <= 1'b0;
                else if (wr_data[CMD_START])
                    run <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            case (rd_addr)
                ADR_MODE: rd_data <= DW'(mode);
                ADR_CPA:  rd_data <= DW'(cmp_a);
                ADR_CPB:  rd_data <= DW'(cmp_b);
                ADR_PER:  rd_data <= DW'(per);
                ADR_CNT:  rd_data <= DW'(cnt);
                default:  rd_data <= '0;
            endcase
        end
    end

endmodule

// File: rtl/wavetmr_tick.sv
module wavetmr_tick
    import wavetmr_pkg::*;
#(
    parameter int unsigned DIVS [N_DIV] = '{1, 8, 32, 128}
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] sel,
    input  logic       slow_tick,
    output logic       tick
);

    logic [N_DIV-1:0] pre_tk;

    for (genvar g = 0; g < N_DIV; g++) begin : g_div
        if (DIVS[g] <= 1) begin : g_pass
            assign pre_tk[g] = 1'b1;
        end else begin : g_cnt
            localparam int PW = $clog2(DIVS[g]);
            localparam logic [PW-1:0] LAST = PW'(DIVS[g] - 1);
            logic [PW-1:0] pc;
            always_ff @(posedge clk) begin
                if (rst || pc == LAST)
                    pc <= '0;
                else
                    pc <= pc + 1'b1;
            end
            assign pre_tk[g] = (pc == LAST);
        end
    end

    always_comb begin
        case (sel)
            3'd0:    tick = pre_tk[0];
            3'd1:    tick = pre_tk[1];
            3'd2:    tick = pre_tk[2];
            3'd3:    tick = pre_tk[3];
            3'd4:    tick = slow_tick;
            default: tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/wavetmr_count.sv
module wavetmr_count #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          wave_en,
    input  logic          tick,
    input  logic          sw_fire,
    input  logic [CW-1:0] cmp_a,
    input  logic [CW-1:0] cmp_b,
    input  logic [CW-1:0] per,
    output logic [CW-1:0] cnt,
    output logic          adv,
    output logic          hit_a,
    output logic          hit_b,
    output logic          hit_p
);

    assign adv   = run && wave_en && tick && !sw_fire;
    assign hit_a = adv && (cnt == cmp_a);
    assign hit_b = adv && (cnt == cmp_b);
    assign hit_p = adv && (cnt == per);

    always_ff @(posedge clk) begin
        if (rst || sw_fire)
            cnt <= '0;
        else if (hit_p)
            cnt <= '0;
        else if (adv)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/wavetmr_pin.sv
module wavetmr_pin
    import wavetmr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sw_fire,
    input  logic hit_own,
    input  logic hit_per,
    input  act_e act_sw,
    input  act_e act_per,
    input  act_e act_own,
    output logic level
);

    always_ff @(posedge clk) begin
        if (rst)
            level <= 1'b0;
        else if (sw_fire)
            level <= apply_act(level, act_sw);
        else if (hit_per)
            level <= apply_act(level, act_per);
        else if (hit_own)
            level <= apply_act(level, act_own);
    end

endmodule

// File: rtl/wavetmr_chan.sv
module wavetmr_chan
    import wavetmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int unsigned DIVS [N_DIV] = '{1, 8, 32, 128}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_tick,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [2:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              pwm_a,
    output logic              pwm_b
);

    mode_t            mode;
    logic [CNT_W-1:0] cmp_a, cmp_b, per, cnt;
    logic             run, sw_fire, tick, adv;
    logic             hit_a, hit_b, hit_p;
    logic [N_PIN-1:0] hit_own, pin_lvl;
    act_e             act_sw  [N_PIN];
    act_e             act_per [N_PIN];
    act_e             act_own [N_PIN];

    wavetmr_regs #(.DW(DATA_W), .CW(CNT_W)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .cnt(cnt), .rd_data(rd_data),
        .mode(mode), .cmp_a(cmp_a), .cmp_b(cmp_b), .per(per),
        .run(run), .sw_fire(sw_fire)
    );

    wavetmr_tick #(.DIVS(DIVS)) u_tick (
        .clk(clk), .rst(rst), .sel(mode.clk_sel),
        .slow_tick(slow_tick), .tick(tick)
    );

    wavetmr_count #(.CW(CNT_W)) u_count (
        .clk(clk), .rst(rst), .run(run), .wave_en(mode.wave_en),
        .tick(tick), .sw_fire(sw_fire),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .per(per),
        .cnt(cnt), .adv(adv), .hit_a(hit_a), .hit_b(hit_b), .hit_p(hit_p)
    );

    assign hit_own    = {hit_b, hit_a};
    assign act_sw[0]  = mode.a_sw;
    assign act_per[0] = mode.a_rc;
    assign act_own[0] = mode.a_cmp;
    assign act_sw[1]  = mode.b_sw;
    assign act_per[1] = mode.b_rc;
    assign act_own[1] = mode.b_cmp;

    for (genvar p = 0; p < N_PIN; p++) begin : g_pin
        wavetmr_pin u_pin (
            .clk(clk), .rst(rst), .sw_fire(sw_fire),
            .hit_own(hit_own[p]), .hit_per(hit_p),
            .act_sw(act_sw[p]), .act_per(act_per[p]), .act_own(act_own[p]),
            .level(pin_lvl[p])
        );
    end

    assign pwm_a = pin_lvl[0];
    assign pwm_b = pin_lvl[1];

endmodule

// File: rtl/wavetmr_chk.sv
module wavetmr_chk
    import wavetmr_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          run,
    input logic          sw_fire,
    input logic          adv,
    input logic          hit_p,
    input logic [CW-1:0] cnt,
    input act_e          a_sw,
    input act_e          b_sw,
    input logic          pwm_a,
    input logic          pwm_b
);

    AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
        adv && !hit_p |=> cnt == CW'($past(cnt) + 1'b1)); // R2

    AST_PER_WRAP: assert property (@(posedge clk) disable iff (rst)
        hit_p |=> cnt == '0); // R2

    AST_TRIG_ZERO: assert property (@(posedge clk) disable iff (rst)
        sw_fire |=> cnt == '0); // R6

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !run && !sw_fire |=> $stable(cnt) && $stable(pwm_a) && $stable(pwm_b)); // R6

    AST_TRIG_SET_A: assert property (@(posedge clk) disable iff (rst)
        sw_fire && a_sw == ACT_SET |=> pwm_a); // R7

    AST_TRIG_CLR_B: assert property (@(posedge clk) disable iff (rst)
        sw_fire && b_sw == ACT_CLR |=> !pwm_b); // R7

endmodule

bind wavetmr_chan wavetmr_chk #(.CW(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .run(run), .sw_fire(sw_fire), .adv(adv),
    .hit_p(hit_p), .cnt(cnt), .a_sw(mode.a_sw), .b_sw(mode.b_sw),
    .pwm_a(pwm_a), .pwm_b(pwm_b)
);

// File: tb/sim_wavetmr_chan.sv
`timescale 1ns/1ps
module sim_wavetmr_chan;

    localparam int DW = 32;
    localparam logic [1:0] NO = 2'd0, ST = 2'd1, CL = 2'd2, TG = 2'd3;
    localparam logic [2:0] A_MODE = 3'd0, A_CMD = 3'd1, A_CPA = 3'd2,
                           A_CPB = 3'd3, A_PER = 3'd4, A_CNT = 3'd5;
    localparam logic [DW-1:0] GO = 32'h5, HALT = 32'h6;

    // pin, reversed, compare, period, expected high samples over two periods
    localparam int NV = 6;
    localparam logic [25:0] VEC [NV] = '{
        {1'b0, 1'b0, 8'd1, 8'd5, 8'd4},
        {1'b0, 1'b1, 8'd1, 8'd5, 8'd8},
        {1'b1, 1'b0, 8'd3, 8'd9, 8'd8},
        {1'b1, 1'b1, 8'd3, 8'd9, 8'd12},
        {1'b0, 1'b0, 8'd0, 8'd3, 8'd2},
        {1'b1, 1'b0, 8'd6, 8'd7, 8'd14}
    };

    logic clk = 0, rst = 1, slow_tick = 0;
    logic wr_en = 0, rd_en = 0;
    logic [2:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic pwm_a, pwm_b;
    int total = 0, bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    wavetmr_chan u0 (
        .clk(clk), .rst(rst), .slow_tick(slow_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    function automatic logic [DW-1:0] mk(input logic [2:0] sel, input logic we,
        input logic [1:0] ac, input logic [1:0] ar, input logic [1:0] as,
        input logic [1:0] bc, input logic [1:0] br, input logic [1:0] bs);
        return {16'h0, bs, br, bc, as, ar, ac, we, sel};
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        rd_en = 1; rd_addr = a;
        @(negedge clk);
        rd_en = 0;
        d = rd_data;
    endtask

    task automatic count_high(input bit pin, input int n, output int h);
        h = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            h += int'(pin ? pwm_b : pwm_a);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d, d2;
        int h, gap;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        chk(pwm_a == 0 && pwm_b == 0, "R1 outputs", {pwm_b, pwm_a}, 0);
        rd(A_CNT, d);  chk(d == 0, "R1 counter", d, 0);
        rd(A_MODE, d); chk(d == 0, "R1 mode", d, 0);

        // R10/R12 readback, upper bits read 0
        wr(A_MODE, 32'hFFFF_1234);
        rd(A_MODE, d); chk(d == 32'h1234, "R10 mode readback", d, 32'h1234);
        wr(A_PER, 32'd77);
        rd(A_PER, d); chk(d == 77, "R12 period readback", d, 77);

        // R10 waveform enable clear: counter frozen
        wr(A_MODE, mk(3'd0, 1'b0, NO, NO, NO, NO, NO, NO));
        wr(A_PER, 32'd50);
        wr(A_CMD, GO);
        repeat (10) @(negedge clk);
        rd(A_CNT, d); chk(d == 0, "R10 wave off", d, 0);

        // vector table: R3 / R4 / R5
        for (int i = 0; i < NV; i++) begin
            logic [25:0] e;
            bit pin, inv;
            logic [1:0] oc, orc, osw;
            int cp, pr, ex;
            string tg;
            e = VEC[i];
            pin = e[25]; inv = e[24];
            cp = int'(e[23:16]); pr = int'(e[15:8]); ex = int'(e[7:0]);
            oc = inv ? ST : CL; orc = inv ? CL : ST; osw = inv ? CL : ST;
            wr(A_CMD, HALT);
            if (pin) wr(A_MODE, mk(3'd0, 1'b1, NO, NO, NO, oc, orc, osw));
            else     wr(A_MODE, mk(3'd0, 1'b1, oc, orc, osw, NO, NO, NO));
            wr(pin ? A_CPB : A_CPA, DW'(cp));
            wr(A_PER, DW'(pr));
            wr(A_CMD, GO);
            repeat (3) @(negedge clk);
            count_high(pin, 2 * (pr + 1), h);
            tg = inv ? "R5 reversed duty" : (pin ? "R4 B duty" : "R3 A duty");
            chk(h == ex, tg, h, ex);
            if (i == 0) begin
                // R2 period: spacing between rising edges of A
                while (!(pwm_a == 0)) @(negedge clk);
                while (!(pwm_a == 1)) @(negedge clk);
                gap = 0;
                do begin @(negedge clk); gap++; end while (!(pwm_a == 0));
                while (!(pwm_a == 1)) begin @(negedge clk); gap++; end
                chk(gap == pr + 1, "R2 period", gap, pr + 1);
                for (int k = 0; k < 8; k++) begin
                    rd(A_CNT, d);
                    chk(d <= DW'(pr), "R2 counter bound", d, pr);
                end
            end
        end

        // R6 0% on A, 100% on B while stopped
        wr(A_MODE, mk(3'd0, 1'b1, NO, NO, CL, NO, NO, ST));
        wr(A_PER, 32'd5);
        wr(A_CMD, HALT | 32'h4);
        count_high(1'b0, 20, h); chk(h == 0, "R6 zero duty A", h, 0);
        count_high(1'b1, 20, h); chk(h == 20, "R6 full duty B", h, 20);
        rd(A_CNT, d); repeat (5) @(negedge clk); rd(A_CNT, d2);
        chk(d == 0 && d2 == 0, "R6 stopped counter", d2, 0);

        // R6 stop without trigger holds the counter value
        wr(A_MODE, mk(3'd0, 1'b1, NO, NO, NO, NO, NO, NO));
        wr(A_PER, 32'd1000);
        wr(A_CMD, GO);
        repeat (20) @(negedge clk);
        wr(A_CMD, 32'h2);
        rd(A_CNT, d); repeat (6) @(negedge clk); rd(A_CNT, d2);
        chk(d == d2 && d != 0, "R6 stop holds", d2, d);

        // R7 own compare equal to period: period action wins
        wr(A_MODE, mk(3'd0, 1'b1, CL, ST, ST, NO, NO, NO));
        wr(A_CPA, 32'd4); wr(A_PER, 32'd4);
        wr(A_CMD, GO);
        count_high(1'b0, 20, h); chk(h == 20, "R7 compare eq period", h, 20);

        // R7 trigger on a period match cycle (period 0)
        wr(A_MODE, mk(3'd0, 1'b1, NO, ST, CL, NO, NO, NO));
        wr(A_PER, 32'd0);
        wr(A_CMD, GO);
        chk(pwm_a == 0, "R7 trigger first", pwm_a, 0);
        @(negedge clk);
        chk(pwm_a == 1, "R7 period after trigger", pwm_a, 1);
        wr(A_CMD, 32'h4);
        chk(pwm_a == 0, "R7 trigger beats period", pwm_a, 0);
        @(negedge clk);
        chk(pwm_a == 1, "R7 period resumes", pwm_a, 1);

        // R8 toggle on period match
        wr(A_MODE, mk(3'd0, 1'b1, NO, TG, CL, NO, NO, NO));
        wr(A_PER, 32'd3);
        wr(A_CMD, GO);
        count_high(1'b0, 16, h); chk(h == 8, "R8 toggle", h, 8);

        // R11 live compare update
        wr(A_MODE, mk(3'd0, 1'b1, CL, ST, ST, NO, NO, NO));
        wr(A_CPA, 32'd1); wr(A_PER, 32'd9);
        wr(A_CMD, GO);
        repeat (4) @(negedge clk);
        wr(A_CPA, 32'd7);
        repeat (12) @(negedge clk);
        count_high(1'b0, 20, h); chk(h == 16, "R11 live update", h, 16);

        // R9 divide-by-8 tick
        wr(A_MODE, mk(3'd1, 1'b1, CL, ST, ST, NO, NO, NO));
        wr(A_CPA, 32'd0); wr(A_PER, 32'd1);
        wr(A_CMD, GO);
        repeat (20) @(negedge clk);
        count_high(1'b0, 32, h); chk(h == 16, "R9 divide by 8", h, 16);

        // R9 slow tick source and unused codes
        wr(A_MODE, mk(3'd4, 1'b1, NO, NO, NO, NO, NO, NO));
        wr(A_PER, 32'd100);
        wr(A_CMD, GO);
        repeat (10) @(negedge clk);
        rd(A_CNT, d); chk(d == 0, "R9 slow idle", d, 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); slow_tick = 1;
            @(negedge clk); slow_tick = 0;
        end
        rd(A_CNT, d); chk(d == 3, "R9 slow ticks", d, 3);
        wr(A_MODE, mk(3'd6, 1'b1, NO, NO, NO, NO, NO, NO));
        repeat (10) @(negedge clk);
        rd(A_CNT, d2); chk(d2 == 3, "R9 no tick code", d2, 3);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule